// File: doc/BRIEF.md
# Power-Up Write Lockout Timer

This block decides, cycle by cycle, whether a write arriving on an asynchronous-SRAM-style memory bus may reach the page-write engine behind it. Two conditions must both hold. First, the supply must be valid, and it must have stayed valid without a break for a programmable number of clock cycles. Second, the bus strobes must be in the write state: chip select active (low), output enable inactive (high) and write strobe active (low). If any strobe is in another state, the write is inhibited.

Supply validity arrives as a digital level from an external detector, which trips at roughly 1.8 V. The input is assumed to be already synchronous to `clk`. The default hold-off of 2,500,000 cycles equals about 10 ms at 250 MHz. Setting the delay to zero removes the timer, and the block then applies only the supply and strobe rules. When the supply is lost, the accumulated count is discarded, so the full hold-off starts again when the supply returns. The permit output is registered, which gives one cycle of latency from the inputs.

Top module: `pwr_wr_lockout`

## Requirements
- R1: While `rst_n` is low, `wr_permit` is 0 whatever the other inputs are.
- R2: `wr_permit` stays 0 until `supply_ok` has been high at DELAY_CYCLES consecutive rising clock edges.
- R3: Once the timeout has elapsed, `wr_permit` is 1 in the cycle after an edge that sees `cs_n`=0, `oe_n`=1, `we_n`=0 with `supply_ok`=1. It is 0 after any other edge.
- R4: An edge that sees `oe_n`=0 makes `wr_permit` 0 in the following cycle.
- R5: An edge that sees `cs_n`=1 makes `wr_permit` 0 in the following cycle.
- R6: An edge that sees `we_n`=1 makes `wr_permit` 0 in the following cycle.
- R7: An edge that sees `supply_ok`=0 makes `wr_permit` 0 in the following cycle. The timeout then restarts from zero, so a further DELAY_CYCLES edges with supply high are needed.
- R8: A supply drop of any length, including a single cycle, before the timeout has elapsed discards the partial count.
- R9: After the timeout, the count saturates. Permission remains available for any length of continuous supply, with no wrap-around.
- R10: With DELAY_CYCLES = 0, `wr_permit` follows the supply and strobe rules one cycle later, with no hold-off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset to the locked state |
| supply_ok | input | 1 | Synchronous supply-valid level from the external detector |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| wr_permit | output | 1 | Registered write permission to the page-write engine |

## Verification
The hardest case to reach from the ports is a supply glitch that lands partway through the hold-off. A correct design must show exactly the full DELAY_CYCLES gap again, counted from the return of the supply rather than from the first rise. The stimulus shortens the delay by parameter. It raises the supply for a partial window, drops it for one cycle, raises it again, and then samples just before and just after the expected release edge. A second instance built with zero delay is driven with the same stimulus to exercise the variant without a timer. A long saturated hold and a random phase with rare supply drops are both compared on every clock against a behavioural model.

// File: rtl/lockout_pkg.sv
package lockout_pkg;

   // Bus control strobes, all active low
   typedef struct packed {
      logic cs_n;
      logic oe_n;
      logic we_n;
   } bus_strobe_t;

   // True only for the single strobe combination that forms a write
   function automatic logic strobes_form_write(bus_strobe_t s);
      return (!s.cs_n) && s.oe_n && (!s.we_n);
   endfunction

   // Counter width able to hold 0..limit
   function automatic int unsigned count_width(int unsigned limit);
      return (limit < 2) ? 1 : $clog2(limit + 1);
   endfunction

endpackage

// File: rtl/lockout_timer.sv
module lockout_timer #(
   parameter int unsigned DELAY_CYCLES = 2500000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic supply_ok,
   output logic timed_out
);
   import lockout_pkg::*;

   localparam int unsigned CNT_W = count_width(DELAY_CYCLES);

   generate
      if (DELAY_CYCLES == 0) begin : g_no_timer
         logic unused_inputs;
         assign unused_inputs = &{1'b0, clk, rst_n, supply_ok};
         assign timed_out = 1'b1;
      end else begin : g_timer
         localparam logic [CNT_W-1:0] LIMIT = CNT_W'(DELAY_CYCLES);
         logic [CNT_W-1:0] run_cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               run_cnt <= '0;
            end else if (!supply_ok) begin
               run_cnt <= '0;
            end else if (run_cnt != LIMIT) begin
               run_cnt <= run_cnt + CNT_W'(1);
            end
         end

         assign timed_out = (run_cnt == LIMIT);
      end
   endgenerate

endmodule

// File: rtl/strobe_inhibit.sv
module strobe_inhibit (
   input  lockout_pkg::bus_strobe_t strobes,
   output logic                     write_ok
);
   import lockout_pkg::*;

   assign write_ok = strobes_form_write(strobes);

endmodule

// File: rtl/pwr_wr_lockout.sv
module pwr_wr_lockout #(
   parameter int unsigned DELAY_CYCLES = 2500000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic supply_ok,
   input  logic cs_n,
   input  logic oe_n,
   input  logic we_n,
   output logic wr_permit
);
   import lockout_pkg::*;

   if (DELAY_CYCLES > 32'h7FFF_FFFF) begin : g_bad_delay
      $error("pwr_wr_lockout: DELAY_CYCLES out of range");
   end

   bus_strobe_t strobes;
   logic        timed_out;
   logic        write_ok;
   logic        permit_q;

   assign strobes = '{cs_n: cs_n, oe_n: oe_n, we_n: we_n};

   lockout_timer #(
      .DELAY_CYCLES(DELAY_CYCLES)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .supply_ok (supply_ok),
      .timed_out (timed_out)
   );

   strobe_inhibit u_inhibit (
      .strobes  (strobes),
      .write_ok (write_ok)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         permit_q <= 1'b0;
      end else begin
         permit_q <= supply_ok && timed_out && write_ok;
      end
   end

   assign wr_permit = permit_q;

endmodule

// File: rtl/pwr_wr_lockout_chk.sv
module pwr_wr_lockout_chk #(
   parameter int unsigned DELAY_CYCLES = 2500000
) (
   input logic clk,
   input logic rst_n,
   input logic supply_ok,
   input logic cs_n,
   input logic oe_n,
   input logic we_n,
   input logic wr_permit
);
   // Independent run-length counter of supply-high edges, saturating
   logic [31:0] seen_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_run <= '0;
      end else if (!supply_ok) begin
         seen_run <= '0;
      end else if (seen_run < DELAY_CYCLES) begin
         seen_run <= seen_run + 32'd1;
      end
   end

   // R1: reset holds the output low
   always_comb begin
      if (!rst_n) begin
         a_r1_reset_locked: assert (!wr_permit);
      end
   end

   // R2: permission only once the supply has been high long enough
   a_r2_timeout_met: assert property (@(posedge clk) disable iff (!rst_n)
      wr_permit |-> (seen_run == DELAY_CYCLES));

   a_r4_oe_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_n |=> !wr_permit);

   a_r5_cs_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> !wr_permit);

   a_r6_we_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      we_n |=> !wr_permit);

   a_r7_supply_drop: assert property (@(posedge clk) disable iff (!rst_n)
      !supply_ok |=> !wr_permit);

   // R9: once granted, permission persists while conditions hold
   a_r9_saturated_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_permit && supply_ok && !cs_n && oe_n && !we_n) |=> wr_permit);

endmodule

bind pwr_wr_lockout pwr_wr_lockout_chk #(
   .DELAY_CYCLES(DELAY_CYCLES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .supply_ok (supply_ok),
   .cs_n      (cs_n),
   .oe_n      (oe_n),
   .we_n      (we_n),
   .wr_permit (wr_permit)
);

// File: tb/pwr_wr_lockout_bench.sv
module pwr_wr_lockout_bench;
   localparam int DLY = 24;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst_n = 1'b0;
   logic supply_ok = 1'b0;
   logic cs_n = 1'b1;
   logic oe_n = 1'b1;
   logic we_n = 1'b1;
   logic permit_a;
   logic permit_b;

   int    errors = 0;
   int    checks = 0;
   string cur_req = "R1";
   bit    done = 1'b0;

   int   run_a = 0;
   logic exp_a = 1'b0;
   logic exp_b = 1'b0;

   pwr_wr_lockout #(.DELAY_CYCLES(DLY)) u_pwr_wr_lockout (
      .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok),
      .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n), .wr_permit(permit_a)
   );

   pwr_wr_lockout #(.DELAY_CYCLES(0)) u_pwr_wr_lockout_nodly (
      .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok),
      .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n), .wr_permit(permit_b)
   );

   task automatic check(string req, logic act, logic exp, string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
      end
   endtask

   // Behavioural reference, compared after every edge
   always @(posedge clk) begin
      logic strobes_write;
      strobes_write = !cs_n && oe_n && !we_n;
      if (!rst_n) begin
         run_a = 0;
         exp_a = 1'b0;
         exp_b = 1'b0;
      end else begin
         exp_a = supply_ok && (run_a == DLY) && strobes_write;
         exp_b = supply_ok && strobes_write;
         if (!supply_ok) run_a = 0;
         else if (run_a < DLY) run_a++;
      end
      #1;
      if (!done) begin
         check(cur_req, permit_a, exp_a, "model delayed");
         check("R10", permit_b, exp_b, "model no-delay");
      end
   end

   task automatic drive(bit s, bit c, bit o, bit w, int n);
      supply_ok = s; cs_n = c; oe_n = o; we_n = w;
      repeat (n) @(negedge clk);
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      @(negedge clk);
      // R1: reset dominates valid-looking inputs
      cur_req = "R1";
      drive(1, 0, 1, 0, 4);
      check("R1", permit_a, 1'b0, "during reset");
      check("R1", permit_b, 1'b0, "during reset no-delay");
      supply_ok = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);

      cur_req = "R2";
      drive(0, 0, 1, 0, 10);
      check("R2", permit_a, 1'b0, "supply low");
      drive(1, 0, 1, 0, DLY);
      check("R2", permit_a, 1'b0, "edge before timeout");
      cur_req = "R3";
      drive(1, 0, 1, 0, 1);
      check("R3", permit_a, 1'b1, "first edge after timeout");

      cur_req = "R4";
      drive(1, 0, 0, 0, 2);
      check("R4", permit_a, 1'b0, "oe low");
      drive(1, 0, 1, 0, 1);
      check("R4", permit_a, 1'b1, "oe released");
      cur_req = "R5";
      drive(1, 1, 1, 0, 2);
      check("R5", permit_a, 1'b0, "cs high");
      cur_req = "R6";
      drive(1, 0, 1, 1, 2);
      check("R6", permit_a, 1'b0, "we high");

      cur_req = "R9";
      drive(1, 0, 1, 0, 100);
      check("R9", permit_a, 1'b1, "long saturated hold");

      cur_req = "R7";
      drive(0, 0, 1, 0, 1);
      check("R7", permit_a, 1'b0, "supply drop");
      check("R7", permit_b, 1'b0, "supply drop no-delay");
      drive(1, 0, 1, 0, DLY);
      check("R7", permit_a, 1'b0, "restart not yet done");
      drive(1, 0, 1, 0, 1);
      check("R7", permit_a, 1'b1, "restart complete");

      cur_req = "R8";
      drive(0, 0, 1, 0, 3);
      drive(1, 0, 1, 0, 10);
      drive(0, 0, 1, 0, 1);
      drive(1, 0, 1, 0, DLY);
      check("R8", permit_a, 1'b0, "partial count discarded");
      drive(1, 0, 1, 0, 1);
      check("R8", permit_a, 1'b1, "full window after glitch");

      cur_req = "R3";
      for (int i = 0; i < 600; i++) begin
         bit s, c, o, w;
         s = ($urandom % 40) != 0;
         c = ($urandom % 5) == 0;
         o = ($urandom % 5) != 0;
         w = ($urandom % 4) == 0;
         drive(s, c, o, w, 1);
      end

      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual=running expected=finished");
         summary();
         $finish;
      end
   end

endmodule